// File: doc/BRIEF.md
# Real-Mode Interrupt Entry Sequencer

This block carries out interrupt entry for a processor running in real-address mode. A one-cycle start pulse hands it an 8-bit vector number together with the current flags word, code segment, instruction pointer, stack pointer, the limit of the vector table and a flag that says whether the stack has room for six bytes. The block copies these values into registers and then checks the vector against the table limit and the stack room. If both checks pass, it saves the return state as three 16-bit words on the stack. It then fetches the four-byte far pointer for the vector and presents the new code segment, instruction pointer, stack pointer and flags.

All traffic goes through one byte-wide memory port. A read returns its data on the cycle after the request. Writes and reads are issued one byte per cycle, with words stored low byte first. The vector table starts at a base address of zero, so the entry for vector `v` is at byte `4*v`. Stack bytes are addressed by the stack pointer plus a fixed stack base. A fault ends the operation before any memory access and leaves every result register unchanged.

The controller has five states. IDLE waits for start and copies the inputs into registers (IDLE to CHECK). CHECK leads to DONE with a table fault when the limit check fails, to DONE with a stack fault when the room flag is low, and to PUSH otherwise. PUSH writes six bytes, advancing a byte index, and moves to FETCH after the last byte. FETCH issues four reads, collects the returned bytes, commits the results and moves to DONE. DONE raises `done` for one cycle and returns to IDLE.

Top module: `rm_int_seq`

## Requirements
- R1: After reset, `busy`, `done`, `fault_tbl`, `fault_stk` and `mem_req` are 0, and `new_cs`, `new_ip`, `new_sp` and `new_flags` are 0.
- R2: On success, `new_ip` is `{byte[4v+1], byte[4v]}` and `new_cs` is `{byte[4v+3], byte[4v+2]}`, where `v` is the vector. The four table bytes are read in ascending address order, with the upper 16 bits of any offset forced to zero.
- R3: When `4*v+3` is greater than `tbl_limit`, the operation ends with `done` and `fault_tbl` both 1 and `fault_stk` 0. No memory request is made and the `new_*` outputs keep their previous values.
- R4: When the table check passes but `stk_room` is 0, the operation ends with `done` and `fault_stk` both 1 and `fault_tbl` 0, with no memory request and unchanged `new_*` outputs. The table fault takes priority when both conditions hold.
- R5: On success, exactly six byte writes occur, in this order: FLAGS[7:0] at SP-2, FLAGS[15:8] at SP-1, CS low at SP-4, CS high at SP-3, IP low at SP-6 and IP high at SP-5. Addresses are taken modulo 2^16 and the stack base (0 by default) is added.
- R6: On success, `new_sp` equals SP-6 modulo 2^16.
- R7: On success, `new_flags` equals the input flags with bit 9 (interrupt enable), bit 8 (trap) and bit 18 (alignment check) cleared and all other bits unchanged. The pushed flags image holds the values from before this clearing.
- R8: `busy` is 1 from the cycle after start is sampled through the cycle in which `done` is 1. A start pulse while `busy` is 1 is ignored: it does not change the outcome, the results or the number of memory accesses.
- R9: `done` is a one-cycle pulse. It is 1 in the cycle after the 13th rising edge on success, and after the 2nd rising edge on a fault, counting the edge that samples start as the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an interrupt entry (sampled only when idle) |
| vector | input | 8 | Interrupt vector number |
| flags_in | input | 32 | Current flags word |
| cs_in | input | 16 | Current code segment |
| ip_in | input | 16 | Current instruction pointer |
| sp_in | input | 16 | Current stack pointer |
| tbl_limit | input | 16 | Highest valid byte offset of the vector table |
| stk_room | input | 1 | 1 when the stack can take six bytes |
| mem_req | output | 1 | Memory byte request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid the cycle after a read request |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| fault_tbl | output | 1 | Vector beyond table limit (with done) |
| fault_stk | output | 1 | Insufficient stack room (with done) |
| new_cs | output | 16 | Loaded code segment |
| new_ip | output | 16 | Loaded instruction pointer |
| new_sp | output | 16 | Stack pointer after the pushes |
| new_flags | output | 32 | Flags after clearing |

## Verification
Random operations mix vectors, flag words, segments and stack pointers. Their table limits are sometimes above and sometimes below the entry's last byte, and the room flag is random. Together these exercise both fault paths and the success path, and they separate a wrong table index from a wrong byte order within an entry. Directed cases cover the boundaries. A limit exactly at `4v+3` must pass and one byte lower must fault. Both faults at once must report only the table fault. A stack pointer of zero makes the pushes wrap to the top of the address space. Flags with every bit set show that only the three named bits are cleared. A second start pulse in the middle of an operation shows that the block ignores starts while busy.

// File: rtl/rmi_pkg.sv
package rmi_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_PUSH,
        ST_FETCH,
        ST_DONE
    } seq_state_t;

    typedef enum logic [1:0] {
        END_OK,
        END_TBL,
        END_STK
    } end_kind_t;

    localparam int FLAG_TRAP   = 8;
    localparam int FLAG_INTEN  = 9;
    localparam int FLAG_ALIGN  = 18;
    localparam int PUSH_BYTES  = 6;
    localparam int ENTRY_BYTES = 4;

    function automatic logic [31:0] entry_flags(input logic [31:0] f);
        logic [31:0] r;
        r = f;
        r[FLAG_TRAP]  = 1'b0;
        r[FLAG_INTEN] = 1'b0;
        r[FLAG_ALIGN] = 1'b0;
        return r;
    endfunction
endpackage

// File: rtl/rmi_entry_check.sv
module rmi_entry_check (
    input  logic [7:0]  vec,
    input  logic [15:0] limit,
    input  logic        room,
    output logic        tbl_bad,
    output logic        stk_bad
);
    logic [15:0] last_byte;

    always_comb begin
        last_byte = {6'd0, vec, 2'b11};
        tbl_bad   = last_byte > limit;
        stk_bad   = !tbl_bad && !room;
    end
endmodule

// File: rtl/rmi_push_lane.sv
module rmi_push_lane (
    input  logic [2:0]  idx,
    input  logic [15:0] sp,
    input  logic [15:0] flags16,
    input  logic [15:0] cs,
    input  logic [15:0] ip,
    output logic [15:0] offset,
    output logic [7:0]  data
);
    localparam int WORDS = 3;

    logic [15:0] word_val [WORDS];
    logic [1:0]  word_sel;

    generate
        for (genvar w = 0; w < WORDS; w++) begin : g_word
            if (w == 0) begin : g_f
                assign word_val[w] = flags16;
            end else if (w == 1) begin : g_c
                assign word_val[w] = cs;
            end else begin : g_i
                assign word_val[w] = ip;
            end
        end
    endgenerate

    always_comb begin
        word_sel = idx[2:1];
        offset   = sp - {13'd0, word_sel, 1'b0} - 16'd2 + {15'd0, idx[0]};
        data     = 8'h00;
        for (int w = 0; w < WORDS; w++) begin
            if (word_sel == 2'(w)) begin
                data = idx[0] ? word_val[w][15:8] : word_val[w][7:0];
            end
        end
    end
endmodule

// File: rtl/rm_int_seq.sv
module rm_int_seq #(
    parameter int ADDR_W     = 16,
    parameter int STACK_BASE = 0,
    parameter int TBL_BASE   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        vector,
    input  logic [31:0]       flags_in,
    input  logic [15:0]       cs_in,
    input  logic [15:0]       ip_in,
    input  logic [15:0]       sp_in,
    input  logic [15:0]       tbl_limit,
    input  logic              stk_room,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              fault_tbl,
    output logic              fault_stk,
    output logic [15:0]       new_cs,
    output logic [15:0]       new_ip,
    output logic [15:0]       new_sp,
    output logic [31:0]       new_flags
);
    import rmi_pkg::*;

    localparam logic [2:0] LAST_PUSH  = 3'(PUSH_BYTES - 1);
    localparam logic [2:0] LAST_FETCH = 3'(ENTRY_BYTES);

    seq_state_t  state, state_nx;
    end_kind_t   end_q;
    logic [2:0]  idx_q;
    logic [7:0]  vec_q;
    logic [31:0] flags_q;
    logic [15:0] cs_q, ip_q, sp_q, lim_q;
    logic        room_q;
    logic [23:0] fetch_q;

    logic        tbl_bad, stk_bad;
    logic [15:0] push_off;
    logic [7:0]  push_byte;

    rmi_entry_check u_check (
        .vec     (vec_q),
        .limit   (lim_q),
        .room    (room_q),
        .tbl_bad (tbl_bad),
        .stk_bad (stk_bad)
    );

    rmi_push_lane u_lane (
        .idx     (idx_q),
        .sp      (sp_q),
        .flags16 (flags_q[15:0]),
        .cs      (cs_q),
        .ip      (ip_q),
        .offset  (push_off),
        .data    (push_byte)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_CHECK;
            ST_CHECK: state_nx = (tbl_bad || stk_bad) ? ST_DONE : ST_PUSH;
            ST_PUSH:  if (idx_q == LAST_PUSH) state_nx = ST_FETCH;
            ST_FETCH: if (idx_q == LAST_FETCH) state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            end_q     <= END_OK;
            idx_q     <= '0;
            vec_q     <= '0;
            flags_q   <= '0;
            cs_q      <= '0;
            ip_q      <= '0;
            sp_q      <= '0;
            lim_q     <= '0;
            room_q    <= 1'b0;
            fetch_q   <= '0;
            new_cs    <= '0;
            new_ip    <= '0;
            new_sp    <= '0;
            new_flags <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        vec_q   <= vector;
                        flags_q <= flags_in;
                        cs_q    <= cs_in;
                        ip_q    <= ip_in;
                        sp_q    <= sp_in;
                        lim_q   <= tbl_limit;
                        room_q  <= stk_room;
                    end
                end
                ST_CHECK: begin
                    idx_q <= '0;
                    end_q <= tbl_bad ? END_TBL : (stk_bad ? END_STK : END_OK);
                end
                ST_PUSH: begin
                    idx_q <= (idx_q == LAST_PUSH) ? 3'd0 : idx_q + 3'd1;
                end
                ST_FETCH: begin
                    idx_q <= idx_q + 3'd1;
                    if (idx_q == 3'd1) fetch_q[7:0]   <= mem_rdata;
                    if (idx_q == 3'd2) fetch_q[15:8]  <= mem_rdata;
                    if (idx_q == 3'd3) fetch_q[23:16] <= mem_rdata;
                    if (idx_q == LAST_FETCH) begin
                        new_ip    <= fetch_q[15:0];
                        new_cs    <= {mem_rdata, fetch_q[23:16]};
                        new_sp    <= sp_q - 16'(PUSH_BYTES);
                        new_flags <= entry_flags(flags_q);
                    end
                end
                ST_DONE: idx_q <= '0;
                default: idx_q <= '0;
            endcase
        end
    end

    always_comb begin
        busy      = (state != ST_IDLE);
        done      = (state == ST_DONE);
        fault_tbl = done && (end_q == END_TBL);
        fault_stk = done && (end_q == END_STK);
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = 8'h00;
        unique case (state)
            ST_PUSH: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ADDR_W'(STACK_BASE) + ADDR_W'(push_off);
                mem_wdata = push_byte;
            end
            ST_FETCH: begin
                mem_req  = (idx_q < LAST_FETCH);
                mem_addr = ADDR_W'(TBL_BASE) + ADDR_W'({vec_q, idx_q[1:0]});
            end
            default: ;
        endcase
    end
endmodule

module rmi_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic        fault_tbl,
    input logic        fault_stk,
    input logic        mem_req,
    input logic [15:0] new_cs,
    input logic [15:0] new_ip,
    input logic [15:0] new_sp,
    input logic [31:0] new_flags
);
    p_fault_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(fault_tbl && fault_stk));

    p_fault_with_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_tbl || fault_stk) |-> done);

    p_fault_keeps_state_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_tbl || fault_stk) |-> ($stable(new_cs) && $stable(new_ip) && $stable(new_sp)));

    p_fault_no_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_tbl || fault_stk) |-> !mem_req);

    p_mem_only_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    p_flags_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault_tbl && !fault_stk) |->
            (!new_flags[8] && !new_flags[9] && !new_flags[18]));

    p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    p_done_in_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind rm_int_seq rmi_chk u_rmi_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .fault_tbl (fault_tbl),
    .fault_stk (fault_stk),
    .mem_req   (mem_req),
    .new_cs    (new_cs),
    .new_ip    (new_ip),
    .new_sp    (new_sp),
    .new_flags (new_flags)
);

// File: tb/test_rm_int_seq.sv
module test_rm_int_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  vector = '0;
    logic [31:0] flags_in = '0;
    logic [15:0] cs_in = '0, ip_in = '0, sp_in = '0, tbl_limit = '0;
    logic        stk_room = 1'b0;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        busy, done, fault_tbl, fault_stk;
    logic [15:0] new_cs, new_ip, new_sp;
    logic [31:0] new_flags;

    int n_chk = 0;
    int n_bad = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;
    logic [15:0] wr_addr [8];
    logic [7:0]  wr_data [8];
    logic [15:0] rd_addr [8];
    logic [7:0]  mem [65536];

    always #2 clk = ~clk;

    rm_int_seq i_rm_int_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .vector(vector),
        .flags_in(flags_in), .cs_in(cs_in), .ip_in(ip_in), .sp_in(sp_in),
        .tbl_limit(tbl_limit), .stk_room(stk_room),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .fault_tbl(fault_tbl), .fault_stk(fault_stk),
        .new_cs(new_cs), .new_ip(new_ip), .new_sp(new_sp), .new_flags(new_flags)
    );

    always @(posedge clk) begin
        if (rst_n && mem_req) begin
            if (mem_we) begin
                mem[mem_addr] <= mem_wdata;
                if (wr_cnt < 8) begin
                    wr_addr[wr_cnt] = mem_addr;
                    wr_data[wr_cnt] = mem_wdata;
                end
                wr_cnt = wr_cnt + 1;
            end else begin
                mem_rdata <= mem[mem_addr];
                if (rd_cnt < 8) rd_addr[rd_cnt] = mem_addr;
                rd_cnt = rd_cnt + 1;
            end
        end
    end

    function automatic logic [7:0] tbl_byte(input int a);
        return 8'((a * 37 + 11) ^ (a >> 3));
    endfunction

    function automatic logic [31:0] exp_flags(input logic [31:0] f);
        return f & ~32'h0004_0300;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [7:0] v, input logic [31:0] f, input logic [15:0] cs,
                          input logic [15:0] ip, input logic [15:0] sp,
                          input logic [15:0] lim, input logic room, input bit poke);
        logic [15:0] o_cs, o_ip, o_sp;
        logic [31:0] o_fl;
        bit e_tbl, e_stk;
        int cyc;
        int a;
        logic [15:0] ea [6];
        logic [7:0]  ed [6];
        o_cs = new_cs; o_ip = new_ip; o_sp = new_sp; o_fl = new_flags;
        e_tbl = (int'(v) * 4 + 3) > int'(lim);
        e_stk = !e_tbl && !room;
        @(negedge clk);
        wr_cnt = 0; rd_cnt = 0;
        vector = v; flags_in = f; cs_in = cs; ip_in = ip; sp_in = sp;
        tbl_limit = lim; stk_room = room; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        vector = ~v; sp_in = ~sp; flags_in = ~f;
        cyc = 0;
        while (!done && cyc < 40) begin
            if (poke && cyc == 3) start = 1'b1;
            else start = 1'b0;
            @(posedge clk);
            @(negedge clk);
            cyc++;
            check(busy, "R8 busy held", 32'(busy), 1);
        end
        start = 1'b0;
        check(cyc == ((e_tbl || e_stk) ? 1 : 12), "R9 done latency", 32'(cyc),
              (e_tbl || e_stk) ? 1 : 12);
        check(fault_tbl == e_tbl, "R3 table fault", 32'(fault_tbl), 32'(e_tbl));
        check(fault_stk == e_stk, "R4 stack fault", 32'(fault_stk), 32'(e_stk));
        if (e_tbl || e_stk) begin
            check(wr_cnt == 0 && rd_cnt == 0, "R3 R4 no access", 32'(wr_cnt + rd_cnt), 0);
            check(new_cs == o_cs && new_ip == o_ip && new_sp == o_sp && new_flags == o_fl,
                  "R3 R4 state kept", {new_cs, new_ip}, {o_cs, o_ip});
        end else begin
            ea[0] = sp - 16'd2; ed[0] = f[7:0];
            ea[1] = sp - 16'd1; ed[1] = f[15:8];
            ea[2] = sp - 16'd4; ed[2] = cs[7:0];
            ea[3] = sp - 16'd3; ed[3] = cs[15:8];
            ea[4] = sp - 16'd6; ed[4] = ip[7:0];
            ea[5] = sp - 16'd5; ed[5] = ip[15:8];
            check(wr_cnt == 6, "R5 write count", 32'(wr_cnt), 6);
            check(rd_cnt == 4, "R2 read count", 32'(rd_cnt), 4);
            for (int k = 0; k < 6; k++) begin
                check(wr_addr[k] == ea[k] && wr_data[k] == ed[k], "R5 push byte",
                      {wr_addr[k], 8'h0, wr_data[k]}, {ea[k], 8'h0, ed[k]});
            end
            for (int k = 0; k < 4; k++) begin
                check(rd_addr[k] == 16'(int'(v) * 4 + k), "R2 read order",
                      32'(rd_addr[k]), int'(v) * 4 + k);
            end
            a = int'(v) * 4;
            check(new_ip == {tbl_byte(a + 1), tbl_byte(a)}, "R2 new ip", 32'(new_ip),
                  32'({tbl_byte(a + 1), tbl_byte(a)}));
            check(new_cs == {tbl_byte(a + 3), tbl_byte(a + 2)}, "R2 new cs", 32'(new_cs),
                  32'({tbl_byte(a + 3), tbl_byte(a + 2)}));
            check(new_sp == sp - 16'd6, "R6 new sp", 32'(new_sp), 32'(sp - 16'd6));
            check(new_flags == exp_flags(f), "R7 new flags", new_flags, exp_flags(f));
        end
        @(posedge clk);
        @(negedge clk);
        check(!done && !busy, "R9 done pulse", {done, busy}, 0);
    endtask

    initial begin
        #1000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int seed;
        logic [7:0] v;
        seed = $urandom(1234);
        for (int i = 0; i < 65536; i++) mem[i] = (i < 1024) ? tbl_byte(i) : 8'hEE;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!busy && !done && !fault_tbl && !fault_stk && !mem_req, "R1 reset controls",
              {busy, done, fault_tbl, fault_stk, mem_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(new_cs == 0 && new_ip == 0 && new_sp == 0 && new_flags == 0, "R1 reset results",
              {new_cs, new_ip}, 0);

        run_op(8'd0, 32'h0000_0302, 16'h1234, 16'h5678, 16'h2000, 16'h03FF, 1'b1, 1'b0);
        run_op(8'd255, 32'hFFFF_FFFF, 16'hABCD, 16'hEF01, 16'h9000, 16'h03FF, 1'b1, 1'b0);
        run_op(8'd100, 32'h0000_0200, 16'h1111, 16'h2222, 16'h3000, 16'd403, 1'b1, 1'b0);
        run_op(8'd100, 32'h0000_0200, 16'h3333, 16'h4444, 16'h3000, 16'd402, 1'b1, 1'b0);
        run_op(8'd10, 32'h0004_0100, 16'h5555, 16'h6666, 16'h4000, 16'h03FF, 1'b0, 1'b0);
        run_op(8'd200, 32'h0000_0001, 16'h7777, 16'h8888, 16'h4000, 16'd10, 1'b0, 1'b0);
        run_op(8'd200, 32'h0004_0302, 16'h9999, 16'hAAAA, 16'h0000, 16'h03FF, 1'b1, 1'b0);
        run_op(8'd33, 32'h0000_0F00, 16'hBBBB, 16'hCCCC, 16'h5000, 16'h03FF, 1'b1, 1'b1);

        for (int i = 0; i < 60; i++) begin
            v = 8'($urandom);
            run_op(v, $urandom, 16'($urandom), 16'($urandom),
                   16'h1000 + 16'($urandom % 16'hE000),
                   16'(int'(v) * 4 + 3 + ($urandom % 8) - 4),
                   1'(($urandom % 4) != 0), 1'(($urandom % 8) == 0));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule